// File: doc/BRIEF.md
# GPIO Interrupt Channel Selector

This block turns a wide bank of GPIO input lines into a small group of interrupt request outputs. It has eight channels. Each channel is programmed through a small register window with three settings: the GPIO line it watches, whether it is level or edge sensitive, and which polarity counts as active. A channel brings its chosen line through a synchronizer and an optional stability filter, then into a per-channel state machine that drives the channel's request output.

In level mode the output follows the active level of the input. In edge mode the channel responds to one edge direction only and holds a pending flag until software writes a one to clear it. To catch both edges of a pin, software points two channels at the same line with opposite polarities. A select code of 0xFF parks a channel. A select value that names no existing line parks it too. Whenever a channel's source, mode or polarity really changes, the channel passes through a settle phase, so the old source's history cannot raise a false request.

Each channel's state machine has five states. **Off**: the channel is parked. **Settle**: the channel is refilling its synchronizer after a reprogram. **Level**: the output follows the input. **Armed**: the channel waits for its edge. **Pending**: an edge was seen and the output is held high. The transitions are as follows:
- An effective reprogram moves any state to Settle.
- After the fill count, Settle goes to Off if the select is parked, to Armed if the channel is in edge mode, and to Level otherwise.
- Armed goes to Pending when the edge is detected.
- Pending returns to Armed on a clear write, unless a new edge arrives in that same cycle.

Top module: `gpio_irq_sel`

## Requirements
- R1: After reset these registers read as follows: 0x00 reads 0x00000000, 0x04 and 0x08 read 0xFFFFFFFF, 0x0C reads 0x00000000, and 0x10 reads 0x00000000. All interrupt outputs are low.
- R2: The select field of channel n is 8 bits wide. For n below 4 it sits in register 0x04, and from n = 4 upward it sits in 0x08. Its position is bits [8*(n%4)+7 : 8*(n%4)]. The channel watches gpio_in at the index the field holds, and the field reads back as written.
- R3: A select value of 0xFF, or any value not below the number of GPIO lines, parks the channel, and its output stays low whatever the inputs do.
- R4: In register 0x00, bit n sets channel n to edge mode when 1 and to level mode when 0. Bit 16+n makes channel n active-low when 1. Every other bit of this register reads 0.
- R5: In level mode, an input change that is present before clock edge k appears on the output just after edge k+2 (with the filter off). Active-high channels output the input as it is, and active-low channels output it inverted.
- R6: In edge mode, a channel with polarity 0 fires on a rising edge only, and a channel with polarity 1 fires on a falling edge only. For an input change present before edge k, the output goes high just after edge k+3 and stays high.
- R7: Register 0x10 reads the pending flags of all channels in bits [7:0]. Writing a 1 to bit n clears channel n's flag, and its output falls after that write edge. Writing 0 bits has no effect.
- R8: Two edge-mode channels with opposite polarity that watch the same line together report both edges of that line. Each reports only its own edge.
- R9: Channel n's filter value N is held in register 0x0C at bits [4n+2:4n]. When N is not zero, a level change must persist for 8*N consecutive synchronized samples before the detector sees it. A pulse of 8*N-1 samples is ignored, and a pulse that is held long enough arrives 8*N-1 cycles later than it would without the filter.
- R10: A write that changes channel n's select field, edge bit or polarity bit does three things: it drops the channel's output after that write edge, it clears the channel's pending flag, and it blocks detection for four cycles. After that, only a true edge of the new source can fire the channel. A write that leaves a channel's own fields unchanged does not disturb that channel.
- R11: Writes to any address other than 0x00, 0x04, 0x08, 0x0C and 0x10 are ignored, including unaligned addresses. Reads from those other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_in | input | NUM_SRC | Asynchronous GPIO lines to select from |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | NUM_CH | One interrupt request per channel |

## Verification
The main function is exercised with five channels set up together. Two level channels of opposite polarity watch one line, two edge channels of opposite polarity watch a second line, and a plain level channel watches a third line. A table then walks all three lines through patterns that separate a level output from a sticky edge flag and a rising edge from a falling one. Directed sequences then measure the exact cycle at which level and edge outputs move. They also show a filtered pulse one sample short of the limit being ignored while a pulse of exactly the limit passes, and a parked or out-of-range channel ignoring every input. A last set of checks covers reprogramming a pending channel onto a line that is already high, which must not fire until that line produces a real edge, and confirms that writes to unused or unaligned addresses change nothing.

// File: rtl/gpio_irq_sel_pkg.sv
package gpio_irq_sel_pkg;

    // Register offsets; the select split between two words is decoded per channel
    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_SEL_LO = 5'h04;
    localparam logic [4:0] OFS_SEL_HI = 5'h08;
    localparam logic [4:0] OFS_FILT   = 5'h0C;
    localparam logic [4:0] OFS_STAT   = 5'h10;

    localparam int         SEL_W      = 8;
    localparam logic [7:0] SEL_PARKED = 8'hFF;

    typedef enum logic [2:0] {
        CH_OFF,
        CH_SETTLE,
        CH_LEVEL,
        CH_ARMED,
        CH_PENDING
    } ch_state_e;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_sel_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int FLT_W  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [4:0]                    addr,
    input  logic [31:0]                   wdata,
    input  logic [NUM_CH-1:0]             pend,
    output logic [31:0]                   rdata,
    output logic [NUM_CH-1:0][SEL_W-1:0]  sel_q,
    output logic [NUM_CH-1:0]             edge_q,
    output logic [NUM_CH-1:0]             low_q,
    output logic [NUM_CH-1:0][FLT_W-1:0]  flt_q,
    output logic [NUM_CH-1:0]             reprog,
    output logic [NUM_CH-1:0]             clr
);

    localparam int LO_CH = (NUM_CH < 4) ? NUM_CH : 4;

    function automatic logic [4:0] sel_word(input int n);
        return (n < 4) ? OFS_SEL_LO : OFS_SEL_HI;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= {NUM_CH{SEL_PARKED}};
            edge_q <= '0;
            low_q  <= '0;
            flt_q  <= '0;
        end else if (wr_en) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr == OFS_CTRL) begin
                    edge_q[n] <= wdata[n];
                    low_q[n]  <= wdata[16+n];
                end
                if (addr == sel_word(n))
                    sel_q[n] <= wdata[8*(n%4) +: SEL_W];
                if (addr == OFS_FILT)
                    flt_q[n] <= wdata[4*n +: FLT_W];
            end
        end
    end

    // A write only counts as a reprogram if it alters this channel's own fields
    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            reprog[n] = wr_en && (
                ((addr == OFS_CTRL) &&
                 ((wdata[n] != edge_q[n]) || (wdata[16+n] != low_q[n]))) ||
                ((addr == sel_word(n)) &&
                 (wdata[8*(n%4) +: SEL_W] != sel_q[n])));
            clr[n] = wr_en && (addr == OFS_STAT) && wdata[n];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    rdata[n]    = edge_q[n];
                    rdata[16+n] = low_q[n];
                end
            end
            OFS_SEL_LO: begin
                rdata = '1;
                for (int n = 0; n < LO_CH; n++)
                    rdata[8*n +: SEL_W] = sel_q[n];
            end
            OFS_SEL_HI: begin
                rdata = '1;
                for (int n = 4; n < NUM_CH; n++)
                    rdata[8*(n-4) +: SEL_W] = sel_q[n];
            end
            OFS_FILT: begin
                for (int n = 0; n < NUM_CH; n++)
                    rdata[4*n +: FLT_W] = flt_q[n];
            end
            OFS_STAT: rdata[NUM_CH-1:0] = pend;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
    import gpio_irq_sel_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter int SYNC_DEPTH = 2,
    parameter int FLT_W      = 3,
    parameter int FLT_UNIT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_in,
    input  logic [SEL_W-1:0]   sel,
    input  logic               edge_md,
    input  logic               act_low,
    input  logic [FLT_W-1:0]   flt,
    input  logic               reprog,
    input  logic               clr,
    output logic               irq,
    output logic               pend
);

    localparam int             IDX_W      = $clog2(NUM_SRC);
    localparam int             UNIT_W     = $clog2(FLT_UNIT);
    localparam int             CNT_W      = FLT_W + UNIT_W;
    localparam int             SET_W      = $clog2(SYNC_DEPTH + 2);
    localparam logic [SET_W-1:0] SETTLE_LEN = SET_W'(SYNC_DEPTH + 1);
    localparam logic [SEL_W:0] SRC_LIM    = (SEL_W+1)'(NUM_SRC);

    ch_state_e            state_q, state_d;
    logic [SET_W-1:0]     settle_q;
    logic [SYNC_DEPTH-1:0] sync_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     span;
    logic                 filt_q, prev_q;
    logic                 enabled, raw, synced, act_now, act_prev, edge_hit;

    assign enabled  = (sel != SEL_PARKED) && ({1'b0, sel} < SRC_LIM);
    assign raw      = enabled ? gpio_in[sel[IDX_W-1:0]] : 1'b0;
    assign synced   = sync_q[SYNC_DEPTH-1];
    assign span     = {flt, {UNIT_W{1'b0}}};
    assign act_now  = filt_q ^ act_low;
    assign act_prev = prev_q ^ act_low;
    assign edge_hit = act_now && !act_prev;

    // Synchronizer, stability filter and one-sample history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            cnt_q    <= '0;
            filt_q   <= 1'b0;
            prev_q   <= 1'b0;
            settle_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], raw};
            prev_q <= filt_q;
            if (state_q == CH_SETTLE || flt == '0) begin
                filt_q <= synced;
                cnt_q  <= '0;
            end else if (synced == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == span - CNT_W'(1)) begin
                filt_q <= synced;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (reprog)
                settle_q <= SETTLE_LEN;
            else if (state_q == CH_SETTLE && settle_q != '0)
                settle_q <= settle_q - SET_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (reprog) begin
            state_d = CH_SETTLE;
        end else begin
            unique case (state_q)
                CH_OFF:     state_d = CH_OFF;
                CH_SETTLE: begin
                    if (settle_q == '0) begin
                        if (!enabled)     state_d = CH_OFF;
                        else if (edge_md) state_d = CH_ARMED;
                        else              state_d = CH_LEVEL;
                    end
                end
                CH_LEVEL:   state_d = CH_LEVEL;
                CH_ARMED:   if (edge_hit) state_d = CH_PENDING;
                CH_PENDING: if (clr && !edge_hit) state_d = CH_ARMED;
                default:    state_d = CH_OFF;
            endcase
        end
    end

    always_comb begin
        irq  = 1'b0;
        pend = 1'b0;
        unique case (state_q)
            CH_LEVEL:   irq = act_now;
            CH_PENDING: begin
                irq  = 1'b1;
                pend = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel
    import gpio_irq_sel_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int NUM_SRC    = 64,
    parameter int SYNC_DEPTH = 2,
    parameter int FLT_W      = 3,
    parameter int FLT_UNIT   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] gpio_in,
    input  logic               reg_wr_en,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_CH-1:0]  irq_out
);

    logic [NUM_CH-1:0][SEL_W-1:0] cfg_sel;
    logic [NUM_CH-1:0]            cfg_edge;
    logic [NUM_CH-1:0]            cfg_low;
    logic [NUM_CH-1:0][FLT_W-1:0] cfg_flt;
    logic [NUM_CH-1:0]            reprog;
    logic [NUM_CH-1:0]            clr;
    logic [NUM_CH-1:0]            pend;

    gpio_irq_regs #(
        .NUM_CH (NUM_CH),
        .FLT_W  (FLT_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend   (pend),
        .rdata  (reg_rdata),
        .sel_q  (cfg_sel),
        .edge_q (cfg_edge),
        .low_q  (cfg_low),
        .flt_q  (cfg_flt),
        .reprog (reprog),
        .clr    (clr)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        gpio_irq_chan #(
            .NUM_SRC    (NUM_SRC),
            .SYNC_DEPTH (SYNC_DEPTH),
            .FLT_W      (FLT_W),
            .FLT_UNIT   (FLT_UNIT)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .gpio_in (gpio_in),
            .sel     (cfg_sel[n]),
            .edge_md (cfg_edge[n]),
            .act_low (cfg_low[n]),
            .flt     (cfg_flt[n]),
            .reprog  (reprog[n]),
            .clr     (clr[n]),
            .irq     (irq_out[n]),
            .pend    (pend[n])
        );
    end

endmodule

// File: rtl/gpio_irq_sel_chk.sv
module gpio_irq_sel_chk #(
    parameter int NUM_CH = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr_en,
    input logic [4:0]              reg_addr,
    input logic [31:0]             reg_wdata,
    input logic [31:0]             reg_rdata,
    input logic [NUM_CH-1:0]       irq_out,
    input logic [NUM_CH-1:0][7:0]  cfg_sel,
    input logic [NUM_CH-1:0]       cfg_edge
);

    // R11
    stray_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr > 5'h10) || (reg_addr[1:0] != 2'b00)) |-> (reg_rdata == 32'h0));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        localparam logic [4:0] SREG = (n < 4) ? 5'h04 : 5'h08;
        localparam int         SH   = 8 * (n % 4);

        // R3
        parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_sel[n] == 8'hFF) |-> !irq_out[n]);

        // R7
        pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[n] && cfg_edge[n] &&
             !(reg_wr_en && (reg_addr == 5'h00 || reg_addr == 5'h04 ||
                             reg_addr == 5'h08 || reg_addr == 5'h10)))
            |=> irq_out[n]);

        // R7
        status_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == 5'h10) |-> (reg_rdata[n] == (irq_out[n] && cfg_edge[n])));

        // R10
        reprog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr_en && reg_addr == SREG && reg_wdata[SH +: 8] != cfg_sel[n])
            |=> !irq_out[n]);
    end

endmodule

bind gpio_irq_sel gpio_irq_sel_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .cfg_sel   (cfg_sel),
    .cfg_edge  (cfg_edge)
);

// File: tb/gpio_irq_sel_bench.sv
module gpio_irq_sel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int NSRC = 64;

    // {line3, line5, line10, expected irq[4:0]}
    localparam logic [7:0] VEC [5] = '{
        8'b100_00001,
        8'b110_00101,
        8'b011_10110,
        8'b001_11110,
        8'b100_01101
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] gpio_in = '0;
    logic            reg_wr_en = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NCH-1:0]  irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_sel u_gpio_irq_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .gpio_in   (gpio_in),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic seen;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd(5'h00, rv); chk("R1 ctrl reset", rv, 32'h0);
        rd(5'h04, rv); chk("R1 sel_lo reset", rv, 32'hFFFFFFFF);
        rd(5'h08, rv); chk("R1 sel_hi reset", rv, 32'hFFFFFFFF);
        rd(5'h0C, rv); chk("R1 filter reset", rv, 32'h0);
        rd(5'h10, rv); chk("R1 status reset", rv, 32'h0);
        chk("R1 irq reset", {24'h0, irq_out}, 32'h0);

        // R4 control field positions
        wr(5'h00, 32'hFFFFFFFF);
        rd(5'h00, rv); chk("R4 ctrl readback", rv, 32'h00FF00FF);
        wr(5'h00, 32'h0);

        // Setup: ch1 level-low, ch2 edge-rise, ch3 edge-fall; ch6 out of range
        wr(5'h00, 32'h000A_000C);
        wr(5'h04, 32'h0505_0303);
        wr(5'h08, 32'hFF40_FF0A);
        rd(5'h04, rv); chk("R2 sel_lo readback", rv, 32'h0505_0303);
        rd(5'h08, rv); chk("R2 sel_hi readback", rv, 32'hFF40_FF0A);
        idle(8);
        chk("R5 active-low idle", {24'h0, irq_out}, 32'h02);

        // Table: R2 routing, R5 level, R6 one-direction edges, R8 both edges
        for (int i = 0; i < 5; i++) begin
            gpio_in[3]  = VEC[i][7];
            gpio_in[5]  = VEC[i][6];
            gpio_in[10] = VEC[i][5];
            idle(6);
            chk($sformatf("R5 R6 R8 table %0d", i), {27'h0, irq_out[4:0]}, {27'h0, VEC[i][4:0]});
            chk($sformatf("R3 table %0d parked", i), {29'h0, irq_out[7:5]}, 32'h0);
        end

        // R3 parked and out-of-range channels ignore every line
        gpio_in = '1;
        idle(6);
        chk("R3 parked ch5", {31'h0, irq_out[5]}, 32'h0);
        chk("R3 out-of-range ch6", {31'h0, irq_out[6]}, 32'h0);
        gpio_in = 64'h8;
        idle(6);
        chk("R3 restore", {27'h0, irq_out[4:0]}, 32'h0D);

        // R7 status and write-one-to-clear
        rd(5'h10, rv); chk("R7 status pending", rv, 32'h0C);
        wr(5'h10, 32'h0);
        chk("R7 zero write no effect", {28'h0, irq_out[3:0]}, 32'hD);
        wr(5'h10, 32'h4);
        chk("R7 clear ch2", {28'h0, irq_out[3:0]}, 32'h9);
        wr(5'h10, 32'h8);
        chk("R7 clear ch3", {28'h0, irq_out[3:0]}, 32'h1);
        rd(5'h10, rv); chk("R7 status empty", rv, 32'h0);

        // R5 and R6 latency: inputs change before edge k
        gpio_in[5] = 1'b1;
        gpio_in[3] = 1'b0;
        idle(2);
        chk("R5 level not before k+2", {31'h0, irq_out[0]}, 32'h1);
        idle(1);
        chk("R5 level after k+2", {31'h0, irq_out[0]}, 32'h0);
        chk("R6 edge not before k+3", {31'h0, irq_out[2]}, 32'h0);
        idle(1);
        chk("R6 edge after k+3", {28'h0, irq_out[3:0]}, 32'h6);

        // R9 filter N=1 on ch4: 7-sample pulse ignored, 8 samples pass
        wr(5'h0C, 32'h0001_0000);
        rd(5'h0C, rv); chk("R9 filter readback", rv, 32'h0001_0000);
        seen = 1'b0;
        gpio_in[10] = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (i == 7) gpio_in[10] = 1'b0;
            @(negedge clk);
            if (irq_out[4]) seen = 1'b1;
        end
        chk("R9 short pulse ignored", {31'h0, seen}, 32'h0);
        gpio_in[10] = 1'b1;
        idle(9);
        chk("R9 filtered before limit", {31'h0, irq_out[4]}, 32'h0);
        idle(1);
        chk("R9 filtered at limit", {31'h0, irq_out[4]}, 32'h1);

        // R10 reprogram pending ch2 onto a line already high
        gpio_in[6] = 1'b1;
        idle(4);
        rd(5'h10, rv); chk("R10 ch2 pending before", rv, 32'h4);
        wr(5'h04, 32'h0506_0303);
        chk("R10 output dropped", {31'h0, irq_out[2]}, 32'h0);
        chk("R10 others undisturbed", {30'h0, irq_out[1:0]}, 32'h2);
        rd(5'h10, rv); chk("R10 pending cleared", rv, 32'h0);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (irq_out[2]) seen = 1'b1;
        end
        chk("R10 no spurious trigger", {31'h0, seen}, 32'h0);
        gpio_in[6] = 1'b0;
        idle(6);
        gpio_in[6] = 1'b1;
        idle(6);
        chk("R10 new source edge fires", {31'h0, irq_out[2]}, 32'h1);

        // R11 stray addresses
        wr(5'h14, 32'hFFFFFFFF);
        wr(5'h06, 32'hFFFFFFFF);
        rd(5'h14, rv); chk("R11 stray read", rv, 32'h0);
        rd(5'h04, rv); chk("R11 sel_lo intact", rv, 32'h0506_0303);
        rd(5'h00, rv); chk("R11 ctrl intact", rv, 32'h000A_000C);
        rd(5'h0C, rv); chk("R11 filter intact", rv, 32'h0001_0000);

        summary();
        $finish;
    end

endmodule